// File: doc/BRIEF.md
# Video DAC Termination Autodetect Controller

This block decides, once per video frame, whether three video output DACs (composite A, luma B, chroma C) should stay powered. Two digital comparator levels tell whether the composite and luma outputs are terminated. A level of 1 means the output sits on the terminated side of the reference. The chroma DAC has no detector of its own. Each comparator level passes through a two-flop synchronizer. It is captured into a status bit only on a frame-start strobe, so status and power decisions change at frame boundaries and nowhere else.

Two modes are supported. In the reporting mode the status bits are visible and power-down follows the manual bits alone. In the automatic mode, with all three DAC enables set, an unterminated DAC is switched off. Switching off the luma DAC also switches off the chroma DAC. A reconnected cable brings the DACs back at the next strobe that sees the termination.

Top module: `dac_term_ctl`

## Requirements
- R1: On a cycle with `frame_stb_i` high, each status bit takes the value its detector input has held for at least the two preceding cycles. The bit appears on the cycle after the strobe. Status 1 means terminated.
- R2: With `frame_stb_i` low, both status bits hold their value whatever the detector inputs do.
- R3: Reset sets both status bits to 1 (terminated). Right after reset, `pd_o` equals `man_pd_i`.
- R4: The automatic policy applies only when `mode_i` is 2'b01 and all three bits of `dac_en_i` are 1. Otherwise, including mode codes 2'b00, 2'b10 and 2'b11, `pd_o` equals `man_pd_i`.
- R5: With the automatic policy in force and the composite status at 0, `pd_o[0]` (DAC A) is 1.
- R6: With the automatic policy in force and the luma status at 0, both `pd_o[1]` (DAC B) and `pd_o[2]` (DAC C) are 1.
- R7: `pd_o` is always the bitwise OR of `man_pd_i` and the automatic decision. A set manual bit is never cleared.
- R8: A DAC that was switched off automatically is powered again after the first strobe that samples its detector at 1, unless it is switched off manually.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_comp_i | input | 1 | Composite DAC comparator level (1 = terminated) |
| det_luma_i | input | 1 | Luma DAC comparator level (1 = terminated) |
| frame_stb_i | input | 1 | One-cycle frame-start strobe |
| dac_en_i | input | 3 | DAC enables, bit 0 = A, bit 1 = B, bit 2 = C |
| man_pd_i | input | 3 | Manual power-down, same bit order |
| mode_i | input | 2 | 2'b01 = automatic, any other code = report only |
| stat_comp_o | output | 1 | Composite termination status |
| stat_luma_o | output | 1 | Luma termination status |
| pd_o | output | 3 | Final power-down per DAC, bit 0 = A, bit 1 = B, bit 2 = C |

## Verification
The bench toggles the detectors between strobes to catch a design that updates status on every cycle instead of at frame start. It drives the unused mode codes 2'b10 and 2'b11 and partial enable masks, which an incomplete decode would wrongly treat as automatic. A luma-only disconnect must also switch off chroma, and a design that lets chroma follow composite, or neither, leaves DAC C running. Reconnect and manual-override cases catch a latched power-down that never recovers, and an automatic path that clears a manual bit.

// File: rtl/dac_term_ctl.sv
module dac_term_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       det_comp_i,
  input  logic       det_luma_i,
  input  logic       frame_stb_i,
  input  logic [2:0] dac_en_i,
  input  logic [2:0] man_pd_i,
  input  logic [1:0] mode_i,
  output logic       stat_comp_o,
  output logic       stat_luma_o,
  output logic [2:0] pd_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_c, sync_l;
  logic          term_c, term_l;
  logic          auto_on;
  logic [2:0]    auto_pd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_c <= '1;
      sync_l <= '1;
      term_c <= 1'b1;
      term_l <= 1'b1;
    end else begin
      sync_c <= {sync_c[LAST-1:0], det_comp_i};
      sync_l <= {sync_l[LAST-1:0], det_luma_i};
      if (frame_stb_i) begin
        term_c <= sync_c[LAST];
        term_l <= sync_l[LAST];
      end
    end
  end

  assign auto_on     = (mode_i == 2'b01) && (&dac_en_i);
  assign auto_pd     = auto_on ? {~term_l, ~term_l, ~term_c} : 3'b000;
  assign pd_o        = man_pd_i | auto_pd;
  assign stat_comp_o = term_c;
  assign stat_luma_o = term_l;

endmodule

// File: rtl/dac_term_ctl_chk.sv
module dac_term_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_stb_i,
  input logic [2:0] dac_en_i,
  input logic [2:0] man_pd_i,
  input logic [1:0] mode_i,
  input logic       stat_comp_o,
  input logic       stat_luma_o,
  input logic [2:0] pd_o,
  input logic       s2_c,
  input logic       s2_l
);

  logic auto_mode;
  assign auto_mode = (mode_i == 2'b01) && (dac_en_i == 3'b111);

  a_r1_sample: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_i |=> (stat_comp_o == $past(s2_c)) && (stat_luma_o == $past(s2_l)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb_i |=> $stable(stat_comp_o) && $stable(stat_luma_o));

  a_r4_manual_only: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode |-> pd_o == man_pd_i);

  a_r5_comp_off: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && !stat_comp_o) |-> pd_o[0]);

  a_r6_chroma_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && !stat_luma_o) |-> (pd_o[1] && pd_o[2]));

  a_r7_manual_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_o & man_pd_i) == man_pd_i);

  a_r8_powered_when_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_comp_o && stat_luma_o) |-> pd_o == man_pd_i);

endmodule

bind dac_term_ctl dac_term_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb_i(frame_stb_i), .dac_en_i(dac_en_i),
  .man_pd_i(man_pd_i), .mode_i(mode_i), .stat_comp_o(stat_comp_o),
  .stat_luma_o(stat_luma_o), .pd_o(pd_o), .s2_c(sync_c[LAST]), .s2_l(sync_l[LAST])
);

// File: tb/dac_term_ctl_bench.sv
module dac_term_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic det_c = 1, det_l = 1, stb = 0;
  logic [2:0] en = 3'b111, man = 3'b000;
  logic [1:0] mode = 2'b00;
  logic sc, sl;
  logic [2:0] pd;
  int checks = 0, errors = 0;
  logic ec = 1, el = 1;

  always #4 clk = ~clk;

  dac_term_ctl u_dac_term_ctl (
    .clk(clk), .rst_n(rst_n), .det_comp_i(det_c), .det_luma_i(det_l),
    .frame_stb_i(stb), .dac_en_i(en), .man_pd_i(man), .mode_i(mode),
    .stat_comp_o(sc), .stat_luma_o(sl), .pd_o(pd));

  function automatic logic [2:0] exp_pd(input logic tc, input logic tl,
                                        input logic [1:0] m, input logic [2:0] e,
                                        input logic [2:0] mp);
    logic [2:0] a;
    a = (m == 2'b01 && e == 3'b111) ? {~tl, ~tl, ~tc} : 3'b000;
    return mp | a;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poll(input logic c, input logic l);
    @(negedge clk); det_c = c; det_l = l;
    repeat (3) @(negedge clk);
    stb = 1;
    @(negedge clk); stb = 0;
    ec = c; el = l;
  endtask

  task automatic check_all(input string req);
    chk(req, {sl, sc}, {el, ec});
    chk(req, pd, exp_pd(ec, el, mode, en, man));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    man = 3'b010;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 status", {sl, sc}, 2'b11);
    chk("R3 pd", pd, 3'b010);

    man = 3'b000; mode = 2'b01; en = 3'b111;
    poll(1'b1, 1'b0);
    check_all("R6 luma off");
    chk("R6 chroma", pd[2], 1'b1);
    chk("R5 comp kept on", pd[0], 1'b0);

    poll(1'b0, 1'b1);
    check_all("R5 comp off");
    chk("R8 luma back", pd[2:1], 2'b00);

    // R2: detectors toggle without strobe
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); det_c = i[0]; det_l = ~i[0];
    end
    repeat (3) @(negedge clk);
    chk("R2 hold", {sl, sc}, {el, ec});

    // R1: strobe right after a change (before sync) takes the old level
    @(negedge clk); det_c = 1; det_l = 1;
    repeat (3) @(negedge clk);
    @(negedge clk); det_c = 0; stb = 1;
    @(negedge clk); stb = 0;
    chk("R1 sync latency", sc, 1'b1);
    ec = 1; el = 1;

    // R4: non-automatic codes and partial enables
    poll(1'b0, 1'b0);
    foreach (mode_lst[k]) begin end
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); mode = m[1:0]; en = 3'b111; man = 3'b100;
      #1 chk(m == 1 ? "R6 auto" : "R4 mode", pd, exp_pd(ec, el, mode, en, man));
    end
    for (int e = 0; e < 7; e++) begin
      @(negedge clk); mode = 2'b01; en = e[2:0]; man = 3'b001;
      #1 chk("R4 enables", pd, man);
    end

    // R7: manual bit on a DAC that autodetect would keep on
    poll(1'b1, 1'b1);
    @(negedge clk); en = 3'b111; mode = 2'b01; man = 3'b101;
    #1 chk("R7 manual kept", pd, 3'b101);
    chk("R8 reconnect", {sl, sc}, 2'b11);

    // random mix
    for (int n = 0; n < 60; n++) begin
      poll(1'($urandom), 1'($urandom));
      check_all("R1 random poll");
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        mode = 2'($urandom); en = ($urandom % 2) ? 3'b111 : 3'($urandom);
        man = 3'($urandom);
        #1 chk("R7 random pd", pd, exp_pd(ec, el, mode, en, man));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int mode_lst[1];
endmodule